// File: doc/BRIEF.md
# Power-On Strap Latch

This block turns a noisy power-on reset input into a clean internal reset and then records the board-level configuration straps. The straps are read once, when the clean reset releases. They are held unchanged until the next power-on reset. The raw reset is first passed through a synchronizer and a stability counter. The filtered reset drives a small three-state capture machine:

- `ST_HOLD` is the state while in reset. On the first clock after release it latches the straps and moves on through the transition `hold_to_latch`.
- `ST_LATCH` takes one settling cycle, then moves on through `latch_to_run`.
- `ST_RUN` is where the latched configuration is reported as valid. It stays there until the next reset, through the transition `run_stay`.

From the latched straps the block produces four results:

- Host interface: True IDE or PCMCIA.
- Processor operation: free-run or ICE-debug, where the internal processor is held off.
- Firmware source: external ROM or the linear flash array.
- Drive role: single drive, master of two, or slave of two.

The held configuration then controls two other functions. It sets the active level of the host reset pin. It also decides whether two ROM control pins carry the ROM chip select and ROM write enable, or the flash data buffer enable and direction. The role code is readable in a status word.

Top module: `boot_strap_latch`

## Requirements
- R1: While `por_raw_n` is low, `sys_rst_n` is low with no clock delay, and every configuration output is at its default.
- R2: `sys_rst_n` rises on the 18th rising clock edge after `por_raw_n` rises. This is 2 synchronizer stages plus 16 consecutive stable cycles. Any low pulse on `por_raw_n` restarts the count.
- R3: The straps are sampled on the first rising edge after `sys_rst_n` rises. `cfg_valid` goes high on the second such edge and stays high until the next reset.
- R4: A strap change after the sampling edge has no effect on any output until the next power-on reset.
- R5: `ide_mode` is the inverse of `strap_oe`: a strap of 0 selects True IDE and 1 selects PCMCIA. `host_reset` follows `host_rst_pin` as active high in PCMCIA mode and active low in True IDE mode.
- R6: `ice_mode` is the inverse of `strap_run`: 1 selects free-run and 0 selects ICE-debug. `cpu_run` is high only when the configuration is valid and free-run was strapped.
- R7: `fw_in_flash` equals `strap_fwloc`: 0 means external ROM and 1 means flash. When ICE-debug and flash firmware are both latched, `pin_sel_n` carries `fbuf_en_n` and `pin_ctl` carries `fbuf_dir`. Otherwise they carry `rom_cs_n` and `rom_we_n`.
- R8: `drive_role` and `stat_word[3:2]` report the role code as follows, and all other `stat_word` bits are 0:

  | Latched code | Reported role |
  |--------------|---------------|
  | 11 | single drive |
  | 00 | master of two |
  | 10 | slave of two |
  | 01 (unused) | reported as 11 |

- R9: Before `cfg_valid` rises, the outputs hold their defaults:

  | Output | Default |
  |--------|---------|
  | `ide_mode`, `ice_mode`, `fw_in_flash` | 0 |
  | `drive_role` | 11 |
  | `stat_word` | 8'h0C |
  | `cpu_run`, `host_reset` | 0 |
  | pin steering | ROM pins |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_raw_n | input | 1 | Raw power-on reset, active low, may bounce |
| strap_oe | input | 1 | Host mode strap (0 True IDE, 1 PCMCIA) |
| strap_run | input | 1 | Operation strap (1 free-run, 0 ICE-debug) |
| strap_fwloc | input | 1 | Firmware location strap (0 ROM, 1 flash) |
| strap_role | input | 2 | Drive role strap |
| host_rst_pin | input | 1 | Host reset pin, polarity depends on mode |
| rom_cs_n | input | 1 | ROM chip select from processor bus logic |
| rom_we_n | input | 1 | ROM write enable from processor bus logic |
| fbuf_en_n | input | 1 | Flash data buffer enable request |
| fbuf_dir | input | 1 | Flash data buffer direction request |
| sys_rst_n | output | 1 | Filtered internal reset, active low |
| cfg_valid | output | 1 | Latched configuration is valid |
| ide_mode | output | 1 | 1 when True IDE host mode is latched |
| ice_mode | output | 1 | 1 when ICE-debug operation is latched |
| fw_in_flash | output | 1 | 1 when firmware is fetched from flash |
| drive_role | output | 2 | Reported drive role code |
| cpu_run | output | 1 | Internal processor enable |
| host_reset | output | 1 | Host reset, normalized to active high |
| pin_sel_n | output | 1 | Shared pin: ROM select or buffer enable |
| pin_ctl | output | 1 | Shared pin: ROM write or buffer direction |
| stat_word | output | 8 | Status word, role in bits 3:2 |

## Verification
The hardest case to reach from the ports is a low glitch on the raw reset shortly before the stability count would have completed. It has to be shown that the count restarts, rather than continuing from where it stopped. The bench first raises the raw reset and waits part of the window. It then drops the input for one cycle and raises it again. From that second rise it checks that release comes exactly on the 18th edge and not earlier. Strap sampling is pinned in every power-up of the sweep over all 32 strap combinations. After the sampling edge, while the machine is still in `ST_LATCH`, every strap is inverted. The reported values must then still match the original straps.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_LATCH = 2'd1,
        ST_RUN   = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic       ide;
        logic       ice;
        logic       fw_flash;
        logic [1:0] role;
    } strap_cfg_t;

    localparam logic [1:0] ROLE_SINGLE = 2'b11;
    localparam logic [1:0] ROLE_MASTER = 2'b00;
    localparam logic [1:0] ROLE_SLAVE  = 2'b10;
    localparam logic [1:0] ROLE_UNUSED = 2'b01;

    localparam strap_cfg_t CFG_DEFAULT = '{ide: 1'b0, ice: 1'b0, fw_flash: 1'b0, role: ROLE_SINGLE};

endpackage

// File: rtl/por_filter.sv
module por_filter #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic raw_n,
    output logic rst_n_o
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(STABLE_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   rel_q;
    logic                   stable_hi;

    // Assertion passes straight through; release is synchronized.
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge raw_n) begin
                if (!raw_n) sync_q <= '0;
                else        sync_q <= 1'b1;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge raw_n) begin
                if (!raw_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign stable_hi = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge raw_n) begin
        if (!raw_n) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else begin
            if (!stable_hi)            cnt_q <= '0;
            else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
            if (stable_hi && cnt_q == CNT_TOP) rel_q <= 1'b1;
        end
    end

    assign rst_n_o = rel_q;
endmodule

// File: rtl/strap_fsm.sv
module strap_fsm
    import strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  strap_cfg_t straps_i,
    output strap_cfg_t cfg_o,
    output logic       valid_o
);
    cap_state_e state_q, state_d;
    strap_cfg_t cfg_q;

    // State register and strap capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cfg_q   <= CFG_DEFAULT;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLD) cfg_q <= straps_i;
        end
    end

    // Transitions: hold_to_latch, latch_to_run, run_stay.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_LATCH;
            ST_LATCH: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_HOLD;
        endcase
    end

    // Outputs.
    always_comb begin
        valid_o = 1'b0;
        cfg_o   = CFG_DEFAULT;
        unique case (state_q)
            ST_HOLD, ST_LATCH: begin
                valid_o = 1'b0;
                cfg_o   = CFG_DEFAULT;
            end
            ST_RUN: begin
                valid_o = 1'b1;
                cfg_o   = cfg_q;
            end
            default: begin
                valid_o = 1'b0;
                cfg_o   = CFG_DEFAULT;
            end
        endcase
    end
endmodule

// File: rtl/pin_steer.sv
module pin_steer
    import strap_pkg::*;
#(
    parameter int STAT_W   = 8,
    parameter int ROLE_LSB = 2
) (
    input  strap_cfg_t        cfg_i,
    input  logic              valid_i,
    input  logic              host_rst_pin,
    input  logic              rom_cs_n,
    input  logic              rom_we_n,
    input  logic              fbuf_en_n,
    input  logic              fbuf_dir,
    output logic              host_reset,
    output logic              cpu_run,
    output logic              pin_sel_n,
    output logic              pin_ctl,
    output logic [1:0]        role_o,
    output logic [STAT_W-1:0] stat_o
);
    logic remap;

    always_comb begin
        role_o = (cfg_i.role == ROLE_UNUSED) ? ROLE_SINGLE : cfg_i.role;
        stat_o = '0;
        stat_o[ROLE_LSB +: 2] = role_o;
    end

    always_comb begin
        host_reset = 1'b0;
        if (valid_i) host_reset = cfg_i.ide ? ~host_rst_pin : host_rst_pin;
        cpu_run = valid_i & ~cfg_i.ice;
    end

    assign remap = valid_i & cfg_i.ice & cfg_i.fw_flash;

    always_comb begin
        if (remap) begin
            pin_sel_n = fbuf_en_n;
            pin_ctl   = fbuf_dir;
        end else begin
            pin_sel_n = rom_cs_n;
            pin_ctl   = rom_we_n;
        end
    end
endmodule

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 16,
    parameter int STAT_W        = 8,
    parameter int ROLE_LSB      = 2
) (
    input  logic              clk,
    input  logic              por_raw_n,
    input  logic              strap_oe,
    input  logic              strap_run,
    input  logic              strap_fwloc,
    input  logic [1:0]        strap_role,
    input  logic              host_rst_pin,
    input  logic              rom_cs_n,
    input  logic              rom_we_n,
    input  logic              fbuf_en_n,
    input  logic              fbuf_dir,
    output logic              sys_rst_n,
    output logic              cfg_valid,
    output logic              ide_mode,
    output logic              ice_mode,
    output logic              fw_in_flash,
    output logic [1:0]        drive_role,
    output logic              cpu_run,
    output logic              host_reset,
    output logic              pin_sel_n,
    output logic              pin_ctl,
    output logic [STAT_W-1:0] stat_word
);
    strap_cfg_t straps, cfg;

    // Strap pins are stored in the sense of the mode they select.
    assign straps = '{ide: ~strap_oe, ice: ~strap_run, fw_flash: strap_fwloc, role: strap_role};

    por_filter #(
        .SYNC_STAGES  (SYNC_STAGES),
        .STABLE_CYCLES(STABLE_CYCLES)
    ) u_filt (
        .clk    (clk),
        .raw_n  (por_raw_n),
        .rst_n_o(sys_rst_n)
    );

    strap_fsm u_fsm (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .straps_i(straps),
        .cfg_o   (cfg),
        .valid_o (cfg_valid)
    );

    pin_steer #(
        .STAT_W  (STAT_W),
        .ROLE_LSB(ROLE_LSB)
    ) u_steer (
        .cfg_i       (cfg),
        .valid_i     (cfg_valid),
        .host_rst_pin(host_rst_pin),
        .rom_cs_n    (rom_cs_n),
        .rom_we_n    (rom_we_n),
        .fbuf_en_n   (fbuf_en_n),
        .fbuf_dir    (fbuf_dir),
        .host_reset  (host_reset),
        .cpu_run     (cpu_run),
        .pin_sel_n   (pin_sel_n),
        .pin_ctl     (pin_ctl),
        .role_o      (drive_role),
        .stat_o      (stat_word)
    );

    assign ide_mode    = cfg.ide;
    assign ice_mode    = cfg.ice;
    assign fw_in_flash = cfg.fw_flash;
endmodule

// File: rtl/boot_strap_latch_chk.sv
module boot_strap_latch_chk #(
    parameter int STABLE_CYCLES = 16,
    parameter int STAT_W        = 8
) (
    input logic              clk,
    input logic              por_raw_n,
    input logic              host_rst_pin,
    input logic              rom_cs_n,
    input logic              rom_we_n,
    input logic              fbuf_en_n,
    input logic              fbuf_dir,
    input logic              sys_rst_n,
    input logic              cfg_valid,
    input logic              ide_mode,
    input logic              ice_mode,
    input logic              fw_in_flash,
    input logic [1:0]        drive_role,
    input logic              cpu_run,
    input logic              host_reset,
    input logic              pin_sel_n,
    input logic              pin_ctl,
    input logic [STAT_W-1:0] stat_word
);
    localparam int HW = $clog2(STABLE_CYCLES + 4);
    localparam logic [HW-1:0] HI_SAT = HW'(STABLE_CYCLES + 2);

    // Consecutive cycles the raw reset has been high.
    logic [HW-1:0] hi_cnt;
    always_ff @(posedge clk or negedge por_raw_n) begin
        if (!por_raw_n)            hi_cnt <= '0;
        else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
    end

    // R1: raw reset low forces the filtered reset low
    a_r1_reset_follows_raw: assert property (@(posedge clk)
        !por_raw_n |-> !sys_rst_n);

    // R2: release only after the stable window
    a_r2_release_after_window: assert property (@(posedge clk) disable iff (!por_raw_n)
        $rose(sys_rst_n) |-> (hi_cnt >= HW'(STABLE_CYCLES)));

    // R3: valid stays high once reached
    a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!sys_rst_n)
        cfg_valid |=> cfg_valid);

    // R4: latched configuration never moves while valid
    a_r4_cfg_stable: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cfg_valid && $past(cfg_valid)) |->
        ($stable(ide_mode) && $stable(ice_mode) && $stable(fw_in_flash) && $stable(drive_role)));

    // R5: an asserted host reset in True IDE mode comes from a low pin
    a_r5_ide_polarity: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cfg_valid && ide_mode && host_reset) |-> !host_rst_pin);

    // R6: processor never enabled in ICE-debug or before valid
    a_r6_cpu_gate: assert property (@(posedge clk) disable iff (!sys_rst_n)
        cpu_run |-> (cfg_valid && !ice_mode));

    // R7: steered pins carry buffer controls in the remap case
    a_r7_remap_pins: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cfg_valid && ice_mode && fw_in_flash) |-> (pin_sel_n == fbuf_en_n && pin_ctl == fbuf_dir));

    a_r7_rom_pins: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !(ice_mode && fw_in_flash) |-> (pin_sel_n == rom_cs_n && pin_ctl == rom_we_n));

    // R8: unused role code never reported, other status bits clear
    a_r8_role_report: assert property (@(posedge clk)
        (stat_word[3:2] != 2'b01) && (stat_word[3:2] == drive_role) && ((stat_word & 8'hF3) == 8'h00));

    // R9: defaults before valid
    a_r9_defaults: assert property (@(posedge clk)
        !cfg_valid |-> (!host_reset && !cpu_run && !ide_mode && drive_role == 2'b11));
endmodule

bind boot_strap_latch boot_strap_latch_chk #(
    .STABLE_CYCLES(STABLE_CYCLES),
    .STAT_W       (STAT_W)
) u_chk (
    .clk         (clk),
    .por_raw_n   (por_raw_n),
    .host_rst_pin(host_rst_pin),
    .rom_cs_n    (rom_cs_n),
    .rom_we_n    (rom_we_n),
    .fbuf_en_n   (fbuf_en_n),
    .fbuf_dir    (fbuf_dir),
    .sys_rst_n   (sys_rst_n),
    .cfg_valid   (cfg_valid),
    .ide_mode    (ide_mode),
    .ice_mode    (ice_mode),
    .fw_in_flash (fw_in_flash),
    .drive_role  (drive_role),
    .cpu_run     (cpu_run),
    .host_reset  (host_reset),
    .pin_sel_n   (pin_sel_n),
    .pin_ctl     (pin_ctl),
    .stat_word   (stat_word)
);

// File: tb/tb_boot_strap_latch.sv
`timescale 1ns/1ps
module tb_boot_strap_latch;
    logic       clk = 1'b0;
    logic       por_raw_n = 1'b0;
    logic       strap_oe = 1'b1, strap_run = 1'b1, strap_fwloc = 1'b0;
    logic [1:0] strap_role = 2'b11;
    logic       host_rst_pin = 1'b0;
    logic       rom_cs_n = 1'b1, rom_we_n = 1'b0, fbuf_en_n = 1'b0, fbuf_dir = 1'b1;
    logic       sys_rst_n, cfg_valid, ide_mode, ice_mode, fw_in_flash, cpu_run, host_reset;
    logic       pin_sel_n, pin_ctl;
    logic [1:0] drive_role;
    logic [7:0] stat_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    boot_strap_latch dut (
        .clk(clk), .por_raw_n(por_raw_n), .strap_oe(strap_oe), .strap_run(strap_run),
        .strap_fwloc(strap_fwloc), .strap_role(strap_role), .host_rst_pin(host_rst_pin),
        .rom_cs_n(rom_cs_n), .rom_we_n(rom_we_n), .fbuf_en_n(fbuf_en_n), .fbuf_dir(fbuf_dir),
        .sys_rst_n(sys_rst_n), .cfg_valid(cfg_valid), .ide_mode(ide_mode), .ice_mode(ice_mode),
        .fw_in_flash(fw_in_flash), .drive_role(drive_role), .cpu_run(cpu_run),
        .host_reset(host_reset), .pin_sel_n(pin_sel_n), .pin_ctl(pin_ctl), .stat_word(stat_word)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic defaults_chk(input string req);
        host_rst_pin = 1'b1;
        #1;
        chk({req, " valid"}, {7'b0, cfg_valid}, 8'h00);
        chk({req, " stat"}, stat_word, 8'h0C);
        chk({req, " modes"}, {5'b0, ide_mode, ice_mode, fw_in_flash}, 8'h00);
        chk({req, " hostrst/cpu"}, {6'b0, host_reset, cpu_run}, 8'h00);
        chk({req, " pins"}, {6'b0, pin_sel_n, pin_ctl}, {6'b0, rom_cs_n, rom_we_n});
    endtask

    // Raise raw reset and check exact release timing (R2).
    task automatic release_chk();
        @(negedge clk) por_raw_n = 1'b1;
        repeat (17) @(posedge clk);
        @(negedge clk) chk("R2 still low at edge 17", {7'b0, sys_rst_n}, 8'h00);
        @(posedge clk);
        @(negedge clk) chk("R2 released at edge 18", {7'b0, sys_rst_n}, 8'h01);
    endtask

    task automatic run_combo(input logic [4:0] s);
        logic       e_ide, e_ice, e_fw, remap;
        logic [1:0] e_role;
        e_ide  = ~s[4];
        e_ice  = ~s[3];
        e_fw   = s[2];
        e_role = (s[1:0] == 2'b01) ? 2'b11 : s[1:0];
        remap  = e_ice & e_fw;

        @(negedge clk) por_raw_n = 1'b0;
        {strap_oe, strap_run, strap_fwloc, strap_role} = s;
        #1 chk("R1 reset low", {7'b0, sys_rst_n}, 8'h00);
        defaults_chk("R9 in reset");
        release_chk();
        defaults_chk("R9 after release");
        @(posedge clk);
        // Edge 19 sampled the straps; invert them now (R3, R4).
        @(negedge clk) chk("R3 not valid after sample edge", {7'b0, cfg_valid}, 8'h00);
        {strap_oe, strap_run, strap_fwloc, strap_role} = ~s;
        @(posedge clk);
        @(negedge clk) chk("R3 valid at second edge", {7'b0, cfg_valid}, 8'h01);
        chk("R5 ide_mode", {7'b0, ide_mode}, {7'b0, e_ide});
        chk("R6 ice_mode", {7'b0, ice_mode}, {7'b0, e_ice});
        chk("R6 cpu_run", {7'b0, cpu_run}, {7'b0, ~e_ice});
        chk("R7 fw_in_flash", {7'b0, fw_in_flash}, {7'b0, e_fw});
        chk("R8 role", {6'b0, drive_role}, {6'b0, e_role});
        chk("R8 stat", stat_word, {4'b0, e_role, 2'b0});

        host_rst_pin = 1'b1;
        #1 chk("R5 host reset pin=1", {7'b0, host_reset}, {7'b0, ~e_ide});
        host_rst_pin = 1'b0;
        #1 chk("R5 host reset pin=0", {7'b0, host_reset}, {7'b0, e_ide});

        rom_cs_n = 1'b1; rom_we_n = 1'b0; fbuf_en_n = 1'b0; fbuf_dir = 1'b1;
        #1 chk("R7 pins A", {6'b0, pin_sel_n, pin_ctl}, remap ? 8'h01 : 8'h02);
        rom_cs_n = 1'b0; rom_we_n = 1'b1; fbuf_en_n = 1'b1; fbuf_dir = 1'b0;
        #1 chk("R7 pins B", {6'b0, pin_sel_n, pin_ctl}, remap ? 8'h02 : 8'h01);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 straps ignored", {2'b0, ide_mode, ice_mode, fw_in_flash, drive_role, cfg_valid},
            {2'b0, e_ide, e_ice, e_fw, e_role, 1'b1});
    endtask

    initial begin
        // Glitch restarts the window (R2).
        repeat (3) @(negedge clk);
        por_raw_n = 1'b1;
        repeat (12) @(negedge clk);
        chk("R2 low before window", {7'b0, sys_rst_n}, 8'h00);
        por_raw_n = 1'b0;
        #1 chk("R1 glitch holds reset", {7'b0, sys_rst_n}, 8'h00);
        @(negedge clk);
        release_chk();

        for (int i = 0; i < 32; i++) run_combo(5'(i));

        // Mid-run reset returns outputs to defaults (R1).
        @(negedge clk) por_raw_n = 1'b0;
        #1 chk("R1 async reset", {7'b0, sys_rst_n}, 8'h00);
        defaults_chk("R1 defaults");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(1_500_000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule